// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

A register-mapped timer with several independent channels. Each channel holds a 64-bit interval written as two 32-bit words. Once it is armed, the channel counts that interval down on a timer clock divided by a power of two. When the count runs out, the channel sets its own pending bit in a shared status register. The single interrupt line goes high when any pending bit is set and its enable bit is also set.

The bus side and the counting side run on separate clocks. Enable and arm requests reach the timer clock through two-flop synchronizers, so stopping or starting a channel takes effect a few timer-clock cycles after the bus write. A toggle handshake copies each channel's live count back to the bus side. The two words of the count that software reads always come from the same snapshot.

A channel can run in one-shot mode, where it stops at zero. It can also run in periodic mode, where it reloads from the interval and keeps going. If a channel is loaded with all ones and runs freely, the bitwise complement of its count serves as a rising timestamp.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero, no channel counts and `irq_o` is low.
- R2: Byte offsets are fixed. Offset 0x00 is the interrupt enable register, with bit N belonging to channel N. Offset 0x04 is the status register. Channel N has five registers at base 0x20*N: control at +0x10, interval low at +0x14, interval high at +0x18, count low at +0x1C and count high at +0x20. In the control register, bit 0 is enable, bit 1 is reload (always reads 0), bits 6:4 are the prescale exponent and bit 7 selects one-shot. Writes to the count registers are ignored.
- R3: A control write with enable=1 and reload=1 copies the interval into the count before counting starts. The loaded value is then readable through count low and count high.
- R4: In one-shot mode the channel sets its status bit once when the count runs out, holds a count of 0 and raises no further status.
- R5: In periodic mode an expiring channel reloads the interval and keeps counting, so its status bit sets again after each interval.
- R6: With prescale exponent k, the count decrements once every 2^k timer-clock cycles. An interval of I expires after I decrements.
- R7: Writing 1 to status bit N clears it. Writing 0 leaves it unchanged. A new expiry in the same cycle as the clear wins over the clear.
- R8: `irq_o` is high exactly when some channel has both its status bit and its enable bit set.
- R9: Clearing enable freezes the count a few timer-clock cycles after the write, and the count stays at that value afterwards.
- R10: A periodic channel loaded with all ones yields a bitwise-inverted count that rises over time. Its high word reads all ones.
- R11: An interval of 3 works in periodic mode and expires every 3 prescaled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| tclk_i | input | 1 | Timer source clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| addr_i | input | AW | Byte address of the register |
| we_i | input | 1 | Write strobe, sampled on clk_i |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: two channels, a 64-bit count and two synchronizer stages. The timer clock period of 14 ns does not divide evenly into the 10 ns bus clock, so the crossings are exercised at drifting phase offsets. Channel 1 sits one register stride above channel 0, which tests the stride decode and the count-high word that shares the next 0x20 block. The full 64-bit width makes it possible to check the all-ones timestamp and a non-zero high word. Tick-count windows check the prescaler and the 3-tick period with tolerance for the synchronizer latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned PSW    = 3;
  localparam int unsigned STRIDE = 32;
  localparam int unsigned OFF_IEN  = 'h00;
  localparam int unsigned OFF_STS  = 'h04;
  localparam int unsigned OFF_CTRL = 'h10;
  localparam int unsigned OFF_ILO  = 'h14;
  localparam int unsigned OFF_IHI  = 'h18;
  localparam int unsigned OFF_CLO  = 'h1C;
  localparam int unsigned OFF_CHI  = 'h20;

  typedef struct packed {
    logic           oneshot;
    logic [PSW-1:0] presc;
    logic           enable;
  } ctrl_t;

  function automatic logic [DW-1:0] ctrl_word(ctrl_t c);
    logic [DW-1:0] w;
    w      = '0;
    w[0]   = c.enable;
    w[6:4] = c.presc;
    w[7]   = c.oneshot;
    return w;
  endfunction
endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CW   = 64,
  parameter int unsigned SYNC = 2
) (
  input  logic           tclk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           ld_tgl_i,
  input  logic [CW-1:0]  ival_i,
  input  logic           oneshot_i,
  input  logic [PSW-1:0] presc_i,
  input  logic           ack_tgl_i,
  output logic           exp_tgl_o,
  output logic           snd_tgl_o,
  output logic [CW-1:0]  hold_o
);
  localparam int unsigned PCW = (1 << PSW) - 1;

  logic en_s, ld_s, ack_s, ld_q, ld_edge;
  logic [CW-1:0]  cnt_q, ival_q;
  logic           os_q, halt_q;
  logic [PSW-1:0] k_q;
  logic [PCW-1:0] pcnt_q, pmask;
  logic           tick;

  tmr_sync #(.STAGES(SYNC)) u_en  (.clk_i(tclk_i), .rst_ni, .d_i(en_i),      .q_o(en_s));
  tmr_sync #(.STAGES(SYNC)) u_ld  (.clk_i(tclk_i), .rst_ni, .d_i(ld_tgl_i),  .q_o(ld_s));
  tmr_sync #(.STAGES(SYNC)) u_ack (.clk_i(tclk_i), .rst_ni, .d_i(ack_tgl_i), .q_o(ack_s));

  assign ld_edge = ld_s ^ ld_q;
  assign pmask   = ~({PCW{1'b1}} << k_q);
  assign tick    = (pcnt_q & pmask) == pmask;

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q      <= 1'b0;
      cnt_q     <= '0;
      ival_q    <= '0;
      os_q      <= 1'b0;
      k_q       <= '0;
      halt_q    <= 1'b0;
      pcnt_q    <= '0;
      exp_tgl_o <= 1'b0;
    end else begin
      ld_q <= ld_s;
      if (ld_edge) begin
        // interval and mode bus registers are quiet while the arm toggle crosses
        cnt_q  <= ival_i;
        ival_q <= ival_i;
        os_q   <= oneshot_i;
        k_q    <= presc_i;
        halt_q <= 1'b0;
        pcnt_q <= '0;
      end else if (en_s && !halt_q) begin
        pcnt_q <= pcnt_q + 1'b1;
        if (tick) begin
          if (cnt_q <= CW'(1)) begin
            exp_tgl_o <= ~exp_tgl_o;
            if (os_q) begin
              cnt_q  <= '0;
              halt_q <= 1'b1;
            end else begin
              cnt_q <= ival_q;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  // snapshot sender: hold_o only moves once the bus side has taken the last copy
  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snd_tgl_o <= 1'b0;
      hold_o    <= '0;
    end else if (ack_s == snd_tgl_o) begin
      hold_o    <= cnt_q;
      snd_tgl_o <= ~snd_tgl_o;
    end
  end
endmodule

// File: rtl/tmr_mbox.sv
`timescale 1ns/1ps
module tmr_mbox #(
  parameter int unsigned CW   = 64,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snd_tgl_i,
  input  logic [CW-1:0] hold_i,
  input  logic          exp_tgl_i,
  output logic          ack_tgl_o,
  output logic [CW-1:0] cnt_o,
  output logic          exp_pulse_o
);
  logic snd_s, exp_s, exp_q;

  tmr_sync #(.STAGES(SYNC)) u_snd (.clk_i, .rst_ni, .d_i(snd_tgl_i), .q_o(snd_s));
  tmr_sync #(.STAGES(SYNC)) u_exp (.clk_i, .rst_ni, .d_i(exp_tgl_i), .q_o(exp_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_tgl_o <= 1'b0;
      cnt_o     <= '0;
      exp_q     <= 1'b0;
    end else begin
      exp_q <= exp_s;
      if (snd_s != ack_tgl_o) begin
        cnt_o     <= hold_i;
        ack_tgl_o <= ~ack_tgl_o;
      end
    end
  end

  assign exp_pulse_o = exp_s ^ exp_q;
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH = 2,
  parameter int unsigned CW   = 64,
  parameter int unsigned SYNC = 2,
  parameter int unsigned AW   = 8
) (
  input  logic          clk_i,
  input  logic          tclk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int unsigned HW = CW - DW;

  function automatic logic [AW-1:0] reg_addr(int unsigned ch, int unsigned off);
    return AW'(STRIDE * ch + off);
  endfunction

  logic [N_CH-1:0] ien_q, sts_q, sts_set, ld_tgl_q, ack_tgl;
  logic [N_CH-1:0] exp_tgl, snd_tgl;
  ctrl_t           ctrl_q [N_CH];
  logic [CW-1:0]   ival_q [N_CH];
  logic [CW-1:0]   hold   [N_CH];
  logic [CW-1:0]   cnt_rd [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q    <= '0;
      ld_tgl_q <= '0;
      for (int ch = 0; ch < N_CH; ch++) begin
        ctrl_q[ch] <= '0;
        ival_q[ch] <= '0;
      end
    end else if (we_i) begin
      if (addr_i == AW'(OFF_IEN)) ien_q <= wdata_i[N_CH-1:0];
      for (int ch = 0; ch < N_CH; ch++) begin
        if (addr_i == reg_addr(ch, OFF_CTRL)) begin
          ctrl_q[ch].enable  <= wdata_i[0];
          ctrl_q[ch].presc   <= wdata_i[6:4];
          ctrl_q[ch].oneshot <= wdata_i[7];
          if (wdata_i[0] && wdata_i[1]) ld_tgl_q[ch] <= ~ld_tgl_q[ch];
        end
        if (addr_i == reg_addr(ch, OFF_ILO)) ival_q[ch][DW-1:0] <= wdata_i;
        if (addr_i == reg_addr(ch, OFF_IHI)) ival_q[ch][CW-1:DW] <= wdata_i[HW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else begin
      for (int ch = 0; ch < N_CH; ch++) begin
        if (sts_set[ch])
          sts_q[ch] <= 1'b1;
        else if (we_i && addr_i == AW'(OFF_STS) && wdata_i[ch])
          sts_q[ch] <= 1'b0;
      end
    end
  end

  assign irq_o = |(sts_q & ien_q);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_chan #(.CW(CW), .SYNC(SYNC)) u_chan (
      .tclk_i,
      .rst_ni,
      .en_i      (ctrl_q[g].enable),
      .ld_tgl_i  (ld_tgl_q[g]),
      .ival_i    (ival_q[g]),
      .oneshot_i (ctrl_q[g].oneshot),
      .presc_i   (ctrl_q[g].presc),
      .ack_tgl_i (ack_tgl[g]),
      .exp_tgl_o (exp_tgl[g]),
      .snd_tgl_o (snd_tgl[g]),
      .hold_o    (hold[g])
    );

    tmr_mbox #(.CW(CW), .SYNC(SYNC)) u_mbox (
      .clk_i,
      .rst_ni,
      .snd_tgl_i   (snd_tgl[g]),
      .hold_i      (hold[g]),
      .exp_tgl_i   (exp_tgl[g]),
      .ack_tgl_o   (ack_tgl[g]),
      .cnt_o       (cnt_rd[g]),
      .exp_pulse_o (sts_set[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFF_IEN)) rdata_o[N_CH-1:0] = ien_q;
    if (addr_i == AW'(OFF_STS)) rdata_o[N_CH-1:0] = sts_q;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (addr_i == reg_addr(ch, OFF_CTRL)) rdata_o = ctrl_word(ctrl_q[ch]);
      if (addr_i == reg_addr(ch, OFF_ILO))  rdata_o = ival_q[ch][DW-1:0];
      if (addr_i == reg_addr(ch, OFF_IHI))  rdata_o = DW'(ival_q[ch][CW-1:DW]);
      if (addr_i == reg_addr(ch, OFF_CLO))  rdata_o = cnt_rd[ch][DW-1:0];
      if (addr_i == reg_addr(ch, OFF_CHI))  rdata_o = DW'(cnt_rd[ch][CW-1:DW]);
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk #(
  parameter int unsigned N_CH = 2,
  parameter int unsigned AW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            we_i,
  input logic [31:0]     wdata_i,
  input logic [31:0]     rdata_o,
  input logic            irq_o,
  input logic [N_CH-1:0] sts_q,
  input logic [N_CH-1:0] ien_q,
  input logic [N_CH-1:0] sts_set
);
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q == '0) |-> !irq_o); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R8
  AST_STATUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && sts_set == '0) |=> $stable(sts_q)); // R7

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_RELOAD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == AW'(32 * g + 16)) |-> !rdata_o[1]); // R2
    AST_EXPIRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_set[g] |=> sts_q[g]); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == AW'(4) && wdata_i[g] && !sts_set[g]) |=> !sts_q[g]); // R7
  end
endmodule

bind evt_timer evt_timer_chk #(.N_CH(N_CH), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .sts_q   (sts_q),
  .ien_q   (ien_q),
  .sts_set (sts_set)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  localparam int CLK_PERIOD  = 10;
  localparam int TCLK_PERIOD = 14;
  localparam int AW = 8;

  logic clk_i = 0, tclk_i = 0, rst_ni = 0;
  logic [AW-1:0] addr_i = '0;
  logic we_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic irq_o;

  int checks = 0, errors = 0;
  logic [31:0] rv, a, b;

  always #(CLK_PERIOD/2)  clk_i  = ~clk_i;
  always #(TCLK_PERIOD/2) tclk_i = ~tclk_i;

  evt_timer uut (.clk_i, .tclk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o, .irq_o);

  // {address, write data, expected readback}
  localparam logic [71:0] TBL [8] = '{
    {8'h00, 32'h0000_0003, 32'h0000_0003},
    {8'h14, 32'h1234_5678, 32'h1234_5678},
    {8'h18, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {8'h34, 32'h0000_00AA, 32'h0000_00AA},
    {8'h38, 32'h0000_0005, 32'h0000_0005},
    {8'h10, 32'h0000_00F2, 32'h0000_00F0},
    {8'h30, 32'h0000_0052, 32'h0000_0050},
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] ad, logic [31:0] d);
    @(negedge clk_i);
    addr_i = ad; wdata_i = d; we_i = 1;
    @(negedge clk_i);
    we_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] ad);
    @(negedge clk_i);
    addr_i = ad;
    #1 rv = rdata_o;
  endtask

  task automatic wt(int n);
    repeat (n) @(posedge tclk_i);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    time t_end;
    #(3 * CLK_PERIOD) rst_ni = 1;

    // R1 reset state
    rd(8'h00); chk("R1 ien", rv, 0);
    rd(8'h04); chk("R1 sts", rv, 0);
    rd(8'h10); chk("R1 ctrl", rv, 0);
    rd(8'h1C); chk("R1 cnt lo", rv, 0);
    rd(8'h20); chk("R1 cnt hi", rv, 0);
    chk("R1 irq", irq_o, 0);

    // R2 register map via table
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i][71:64], TBL[i][63:32]);
      rd(TBL[i][71:64]);
      chk($sformatf("R2 addr %0h", TBL[i][71:64]), rv, TBL[i][31:0]);
    end
    wr(8'h10, 0); wr(8'h30, 0);

    // R3 load from interval, both words
    wr(8'h14, 100); wr(8'h18, 3); wr(8'h10, 32'h73);
    wt(20);
    rd(8'h1C); chk("R3 cnt lo", rv, 100);
    rd(8'h20); chk("R3 cnt hi", rv, 3);
    wr(8'h10, 32'h70); wr(8'h18, 0);

    // R4 one-shot
    wr(8'h04, 3);
    wr(8'h14, 5); wr(8'h10, 32'h83);
    wt(30);
    rd(8'h04); chk("R4 oneshot status", rv[0], 1);
    chk("R8 irq high", irq_o, 1);
    rd(8'h1C); chk("R4 oneshot count zero", rv, 0);
    wr(8'h04, 1);
    rd(8'h04); chk("R7 w1c clears", rv[0], 0);
    wt(30);
    rd(8'h04); chk("R4 no second expiry", rv[0], 0);
    chk("R8 irq low", irq_o, 0);

    // R5 R11 R6 periodic interval 3, divide by 4
    wr(8'h34, 3); wr(8'h38, 0); wr(8'h30, 32'h23);
    wt(40);
    rd(8'h04); chk("R5 periodic status", rv[1], 1);
    wr(8'h04, 0);
    rd(8'h04); chk("R7 write zero keeps", rv[1], 1);
    wr(8'h04, 1);
    rd(8'h04); chk("R7 other bit keeps", rv[1], 1);
    wr(8'h04, 2);
    n = 0;
    t_end = $time + 3360;
    while ($time < t_end) begin
      rd(8'h04);
      if (rv[1]) begin n++; wr(8'h04, 2); end
    end
    chk("R11 expiries in 20 periods", (n >= 19 && n <= 21), 1);
    wr(8'h30, 32'h20);
    wt(20);
    wr(8'h04, 3);

    // R6 prescale exponent 3, interval 4 -> 32 timer cycles
    wr(8'h14, 4); wr(8'h10, 32'h33);
    wt(24);
    rd(8'h04); chk("R6 not yet expired", rv[0], 0);
    wt(21);
    rd(8'h04); chk("R6 expired", rv[0], 1);
    wr(8'h10, 32'h30);

    // R8 masking
    wr(8'h00, 0);
    rd(8'h00); chk("R8 masked irq", irq_o, 0);
    wr(8'h00, 1);
    rd(8'h00); chk("R8 unmasked irq", irq_o, 1);
    wr(8'h04, 3);
    rd(8'h04); chk("R8 cleared irq", irq_o, 0);

    // R10 free-running timestamp
    wr(8'h34, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); wr(8'h30, 32'h03);
    wt(20);
    rd(8'h3C); a = ~rv;
    wt(10);
    rd(8'h3C); b = ~rv;
    chk("R10 timestamp rises", (b > a), 1);
    rd(8'h40); chk("R10 hi word", rv, 32'hFFFF_FFFF);

    // R9 disable freezes
    wr(8'h30, 0);
    wt(10);
    rd(8'h3C); a = rv;
    wt(20);
    rd(8'h3C); chk("R9 frozen count", rv, a);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule